// File: doc/BRIEF.md
# Three-Wire Addressed Register Interface

This block is a serial slave on three wires: a bit clock, a data line and a frame strobe. The host raises the strobe, clocks a 32-bit frame and then drops the strobe. Each frame holds an 8-bit address and then a 24-bit payload. Two address codes select write targets. For a write, the payload moves into one of two 24-bit settings registers at the moment the strobe falls. Two other codes select read sources. For a read, one of two 24-bit status buses is snapshotted once the address is known, and its bits are then shifted back to the host on a separate serial output with an output enable.

All three wires are asynchronous to the block clock. A parameterised synchronizer chain brings them into the block clock domain, and edges are detected there. The host must therefore hold each wire phase for several block clocks. The bit clock idles high between frames. As a result, the snapshot edge is the ninth falling edge of the bit clock in a frame.

Top module: `tw_reg_if`

## Requirements
- R1: The data line is sampled on each rising bit-clock edge while the strobe is high, least significant bit first. Frame bits 0 to 7 form the address, and frame bits 8 to 31 form payload bits 0 to 23.
- R2: Address 0xD0 loads the payload into `wr_reg1_o`, and address 0xD2 loads it into `wr_reg2_o`. The load happens only on the falling edge of the strobe, and the register keeps its old value until then.
- R3: A strobe fall commits a write only when exactly 32 rising bit-clock edges were seen during that strobe-high period. With 31 or 33 edges, neither register changes.
- R4: An address other than 0xD0, 0xD1, 0xD2 or 0xD3 changes no register, and `ser_data_oe_o` stays low for the whole frame.
- R5: Address 0xD1 snapshots `rd_word1_i`, and address 0xD3 snapshots `rd_word2_i`. The snapshot is taken on the first falling bit-clock edge after the eighth address bit. Later changes on the status bus do not alter the returned word.
- R6: After the snapshot, `ser_data_o` presents word bit 0. Each later falling bit-clock edge advances it by one bit, so the host reads word bit k at the rising edge of frame bit 8+k.
- R7: `ser_data_oe_o` is high only for a read address, from the snapshot edge until the strobe falls. It is low during the address bits and whenever the strobe is low.
- R8: The bit counter is held at zero while the strobe is low. A frame that follows an aborted frame is received correctly from bit 0.
- R9: After reset, both settings registers hold `RST_WORD` (zero by default), and `ser_data_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock from the host (idles high) |
| ser_strobe_i | input | 1 | Frame strobe: high during a frame, falling edge commits |
| ser_data_i | input | 1 | Serial data from the host |
| ser_data_o | output | 1 | Serial read data to the host |
| ser_data_oe_o | output | 1 | Enable for driving the serial read data |
| rd_word1_i | input | DATA_W | Status word returned for address 0xD1 |
| rd_word2_i | input | DATA_W | Status word returned for address 0xD3 |
| wr_reg1_o | output | DATA_W | Settings register written by address 0xD0 |
| wr_reg2_o | output | DATA_W | Settings register written by address 0xD2 |

## Verification
Some rules hold on every cycle, and the bound checker tracks them. A settings register changes only in the cycle after a strobe fall, and only when the frame had the full bit count. The output enable is never high outside a frame or for an address that is not a read code. It also rises only when the counter sits just past the address bits. The bit counter returns to zero whenever the strobe is low. Other properties can be shown only by driving frames end to end: bit ordering, the mapping of all 256 address values to their targets, the values returned by reads, immunity to status changes after the snapshot, and correct recovery after a short or overlong frame.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;

   // Decoded target of the address byte of the current frame
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_WR1,
      SEL_WR2,
      SEL_RD1,
      SEL_RD2
   } sel_e;

endpackage

// File: rtl/tw_pin_sync.sv
// Multi-bit synchronizer chain; depth chosen by parameter.
module tw_pin_sync #(
   parameter int               WIDTH     = 3,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 1) begin : g_chk_stages
      $error("tw_pin_sync: STAGES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RESET_VAL;
      else        stg[0] <= pin_i;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= RESET_VAL;
         else        stg[k] <= stg[k-1];
      end
   end

   assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/tw_frame_rx.sv
// Receive shift register, bit counter and address latch.
module tw_frame_rx #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 24,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              bit_rise_i,
   input  logic              bit_din_i,
   input  logic              strobe_fall_i,
   output logic [CNT_W-1:0]  bit_cnt_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] payload_o,
   output logic              frame_ok_o
);

   localparam int FRAME_BITS = ADDR_W + DATA_W;
   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);

   logic [FRAME_BITS-1:0] sreg, sreg_nxt;
   logic [CNT_W-1:0]      cnt;
   logic [ADDR_W-1:0]     addr_q;

   // New bits enter at the top: after a full frame the first bit sits at bit 0
   assign sreg_nxt = {bit_din_i, sreg[FRAME_BITS-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         cnt    <= '0;
         addr_q <= '0;
      end else if (!active_i) begin
         cnt <= '0;
      end else if (bit_rise_i) begin
         sreg <= sreg_nxt;
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
         if (cnt == CNT_ADDR) addr_q <= sreg_nxt[FRAME_BITS-1 -: ADDR_W];
      end
   end

   assign bit_cnt_o  = cnt;
   assign addr_o     = addr_q;
   assign payload_o  = sreg[FRAME_BITS-1:ADDR_W];
   assign frame_ok_o = strobe_fall_i && (cnt == CNT_FULL);

endmodule

// File: rtl/tw_read_tx.sv
// Snapshot and serial return of a status word.
module tw_read_tx #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 24,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              bit_fall_i,
   input  logic [CNT_W-1:0]  bit_cnt_i,
   input  logic              rd_hit_i,
   input  logic [DATA_W-1:0] rd_word_i,
   output logic              sdo_o,
   output logic              oe_o
);

   localparam logic [CNT_W-1:0] CNT_CAPT = CNT_W'(ADDR_W);

   logic [DATA_W-1:0] shreg;
   logic              taken;
   logic              oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         taken <= 1'b0;
         oe_q  <= 1'b0;
      end else if (!active_i) begin
         taken <= 1'b0;
         oe_q  <= 1'b0;
      end else if (bit_fall_i) begin
         if (!taken && bit_cnt_i == CNT_CAPT) begin
            taken <= 1'b1;
            if (rd_hit_i) begin
               shreg <= rd_word_i;
               oe_q  <= 1'b1;
            end
         end else if (oe_q) begin
            shreg <= {1'b0, shreg[DATA_W-1:1]};
         end
      end
   end

   assign sdo_o = shreg[0];
   assign oe_o  = oe_q;

endmodule

// File: rtl/tw_reg_if.sv
module tw_reg_if
   import tw_reg_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 24,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] WR1_CODE    = 8'hD0,
   parameter logic [ADDR_W-1:0] WR2_CODE    = 8'hD2,
   parameter logic [ADDR_W-1:0] RD1_CODE    = 8'hD1,
   parameter logic [ADDR_W-1:0] RD2_CODE    = 8'hD3,
   parameter logic [DATA_W-1:0] RST_WORD    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_strobe_i,
   input  logic              ser_data_i,
   output logic              ser_data_o,
   output logic              ser_data_oe_o,
   input  logic [DATA_W-1:0] rd_word1_i,
   input  logic [DATA_W-1:0] rd_word2_i,
   output logic [DATA_W-1:0] wr_reg1_o,
   output logic [DATA_W-1:0] wr_reg2_o
);

   localparam int FRAME_BITS = ADDR_W + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 2);
   localparam int NPIN       = 3;
   // pin order: bit 0 clock (idles high), bit 1 strobe, bit 2 data
   localparam logic [NPIN-1:0] PIN_IDLE = 3'b001;

   // ---------------- elaboration checks ----------------
   if (ADDR_W < 2 || DATA_W < 2) begin : g_chk_width
      $error("tw_reg_if: ADDR_W and DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("tw_reg_if: SYNC_STAGES must be at least 2");
   end
   if (WR1_CODE == WR2_CODE || WR1_CODE == RD1_CODE || WR1_CODE == RD2_CODE ||
       WR2_CODE == RD1_CODE || WR2_CODE == RD2_CODE || RD1_CODE == RD2_CODE) begin : g_chk_codes
      $error("tw_reg_if: address codes must be distinct");
   end
   if ((FRAME_BITS + 1) >= (1 << CNT_W)) begin : g_chk_cnt
      $error("tw_reg_if: counter too narrow");
   end

   // ---------------- pin synchronisation and edges ----------------
   logic [NPIN-1:0] pin_raw, pin_s;
   logic            clk_last, strb_last;
   logic            bit_rise, bit_fall;
   logic            frame_active, strobe_fall;

   assign pin_raw = {ser_data_i, ser_strobe_i, ser_clk_i};

   tw_pin_sync #(
      .WIDTH     (NPIN),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (PIN_IDLE)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_raw),
      .sync_o (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_last  <= PIN_IDLE[0];
         strb_last <= PIN_IDLE[1];
      end else begin
         clk_last  <= pin_s[0];
         strb_last <= pin_s[1];
      end
   end

   assign frame_active = pin_s[1];
   assign bit_rise     = pin_s[0] & ~clk_last;
   assign bit_fall     = ~pin_s[0] & clk_last;
   assign strobe_fall  = ~pin_s[1] & strb_last;

   // ---------------- receiver ----------------
   logic [CNT_W-1:0]  bit_cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] payload;
   logic              frame_ok;

   tw_frame_rx #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .active_i      (frame_active),
      .bit_rise_i    (bit_rise),
      .bit_din_i     (pin_s[2]),
      .strobe_fall_i (strobe_fall),
      .bit_cnt_o     (bit_cnt),
      .addr_o        (addr_q),
      .payload_o     (payload),
      .frame_ok_o    (frame_ok)
   );

   // ---------------- address decode ----------------
   sel_e sel;

   always_comb begin
      if      (addr_q == WR1_CODE) sel = SEL_WR1;
      else if (addr_q == WR2_CODE) sel = SEL_WR2;
      else if (addr_q == RD1_CODE) sel = SEL_RD1;
      else if (addr_q == RD2_CODE) sel = SEL_RD2;
      else                         sel = SEL_NONE;
   end

   // ---------------- settings registers ----------------
   logic [DATA_W-1:0] wr_reg [2];
   logic [1:0]        wr_load;

   assign wr_load[0] = frame_ok && (sel == SEL_WR1);
   assign wr_load[1] = frame_ok && (sel == SEL_WR2);

   for (genvar r = 0; r < 2; r++) begin : g_wreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          wr_reg[r] <= RST_WORD;
         else if (wr_load[r]) wr_reg[r] <= payload;
      end
   end

   assign wr_reg1_o = wr_reg[0];
   assign wr_reg2_o = wr_reg[1];

   // ---------------- read return ----------------
   logic              rd_hit;
   logic [DATA_W-1:0] rd_word;

   assign rd_hit  = (sel == SEL_RD1) || (sel == SEL_RD2);
   assign rd_word = (sel == SEL_RD2) ? rd_word2_i : rd_word1_i;

   tw_read_tx #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (frame_active),
      .bit_fall_i (bit_fall),
      .bit_cnt_i  (bit_cnt),
      .rd_hit_i   (rd_hit),
      .rd_word_i  (rd_word),
      .sdo_o      (ser_data_o),
      .oe_o       (ser_data_oe_o)
   );

endmodule

// File: rtl/tw_reg_if_chk.sv
module tw_reg_if_chk #(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 24,
   parameter int                CNT_W    = 6,
   parameter logic [ADDR_W-1:0] RD1_CODE = 8'hD1,
   parameter logic [ADDR_W-1:0] RD2_CODE = 8'hD3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              active,
   input logic              strobe_fall,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [ADDR_W-1:0] addr_q,
   input logic [DATA_W-1:0] wr1,
   input logic [DATA_W-1:0] wr2,
   input logic              oe
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_W + DATA_W);
   localparam logic [CNT_W-1:0] CNT_CAPT = CNT_W'(ADDR_W);

   AST_WR_ONLY_ON_STROBE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(wr1) || !$stable(wr2)) |-> $past(strobe_fall)); // R2

   AST_WR_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(wr1) || !$stable(wr2)) |-> ($past(bit_cnt) == CNT_FULL)); // R3

   AST_OE_ONLY_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (addr_q == RD1_CODE || addr_q == RD2_CODE)); // R4

   AST_SNAPSHOT_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> (bit_cnt == CNT_CAPT)); // R5

   AST_OE_DROPS_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !oe); // R7

   AST_CNT_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (bit_cnt == '0)); // R8

endmodule

bind tw_reg_if tw_reg_if_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CNT_W    (CNT_W),
   .RD1_CODE (RD1_CODE),
   .RD2_CODE (RD2_CODE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .active      (frame_active),
   .strobe_fall (strobe_fall),
   .bit_cnt     (bit_cnt),
   .addr_q      (addr_q),
   .wr1         (wr_reg1_o),
   .wr2         (wr_reg2_o),
   .oe          (ser_data_oe_o)
);

// File: tb/tb_tw_reg_if.sv
module tb_tw_reg_if;

   localparam int H = 6;  // block clocks per serial half period

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        strb = 1'b0;
   logic        sdin = 1'b0;
   logic        sdo, soe;
   logic [23:0] rd1 = '0, rd2 = '0;
   logic [23:0] wr1, wr2;

   int checks = 0;
   int errors = 0;

   // per-frame observations
   logic [23:0] rx_word;
   logic        oe_addr_phase, oe_at_snap, oe_any, oe_after;
   logic [23:0] pre1, pre2;

   always #4 clk = ~clk;  // 125 MHz

   tw_reg_if dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .ser_clk_i     (sclk),
      .ser_strobe_i  (strb),
      .ser_data_i    (sdin),
      .ser_data_o    (sdo),
      .ser_data_oe_o (soe),
      .rd_word1_i    (rd1),
      .rd_word2_i    (rd2),
      .wr_reg1_o     (wr1),
      .wr_reg2_o     (wr2)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // One frame of nbits bits; status words are inverted after the snapshot
   task automatic run_frame(input logic [7:0] a, input logic [23:0] d, input int nbits);
      logic [31:0] word;
      word = {d, a};
      oe_addr_phase = 1'b0;
      oe_at_snap    = 1'b0;
      oe_any        = 1'b0;
      rx_word       = '0;
      strb = 1'b1;
      wait_clk(H);
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b0;
         sdin = (i < 32) ? word[i] : 1'b0;
         wait_clk(H);
         if (soe) oe_any = 1'b1;
         if (i < 8 && soe) oe_addr_phase = 1'b1;
         if (i == 8) oe_at_snap = soe;
         if (i >= 8 && i < 32) rx_word[i-8] = sdo;
         sclk = 1'b1;
         if (i == 8) begin
            rd1 = ~rd1;
            rd2 = ~rd2;
         end
         wait_clk(H);
      end
      wait_clk(H);
      pre1 = wr1;
      pre2 = wr2;
      strb = 1'b0;
      wait_clk(10);
      oe_after = soe;
      if (nbits > 8) begin
         rd1 = ~rd1;
         rd2 = ~rd2;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [23:0] m1, m2, d, e1, e2;
      logic [7:0]  a;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      // R9: reset state
      chk("R9 wr1", 32'(wr1), 32'h0);
      chk("R9 wr2", 32'(wr2), 32'h0);
      chk("R9 oe", 32'(soe), 32'h0);
      m1 = '0;
      m2 = '0;

      // Sweep every address value
      for (int ai = 0; ai < 256; ai++) begin
         a   = 8'(ai);
         d   = {a ^ 8'h96, ~a, a};
         e1  = {a, 8'h5A, ~a} ^ 24'h0F0F0F;
         e2  = {~a, a ^ 8'hC3, a};
         rd1 = e1;
         rd2 = e2;
         run_frame(a, d, 32);
         if (a == 8'hD0) begin
            chk("R2 wr1 held before strobe fall", 32'(pre1), 32'(m1));
            m1 = d;
            chk("R1 R2 wr1 payload LSB first", 32'(wr1), 32'(m1));
            chk("R2 wr2 untouched", 32'(wr2), 32'(m2));
         end else if (a == 8'hD2) begin
            chk("R2 wr2 held before strobe fall", 32'(pre2), 32'(m2));
            m2 = d;
            chk("R1 R2 wr2 payload LSB first", 32'(wr2), 32'(m2));
            chk("R2 wr1 untouched", 32'(wr1), 32'(m1));
         end else if (a == 8'hD1 || a == 8'hD3) begin
            chk("R5 R6 read word", 32'(rx_word), 32'((a == 8'hD1) ? e1 : e2));
            chk("R7 oe at snapshot", 32'(oe_at_snap), 32'h1);
            chk("R7 oe low in address bits", 32'(oe_addr_phase), 32'h0);
            chk("R7 oe low after strobe", 32'(oe_after), 32'h0);
            chk("R2 read leaves wr1", 32'(wr1), 32'(m1));
            chk("R2 read leaves wr2", 32'(wr2), 32'(m2));
         end else begin
            chk("R4 wr1 unchanged", 32'(wr1), 32'(m1));
            chk("R4 wr2 unchanged", 32'(wr2), 32'(m2));
            chk("R4 oe stays low", 32'(oe_any), 32'h0);
         end
      end

      // R3: short and overlong frames commit nothing
      run_frame(8'hD0, 24'h123456, 31);
      chk("R3 31-bit frame ignored", 32'(wr1), 32'(m1));
      run_frame(8'hD2, 24'h654321, 33);
      chk("R3 33-bit frame ignored", 32'(wr2), 32'(m2));

      // R8: clean restart after an aborted frame
      run_frame(8'hD0, 24'hABCDEF, 13);
      chk("R8 abort leaves wr1", 32'(wr1), 32'(m1));
      run_frame(8'hD0, 24'hC0FFEE, 32);
      chk("R8 frame after abort", 32'(wr1), 32'hC0FFEE);
      rd2 = 24'h81F00D;
      run_frame(8'hD3, 24'h0, 20);
      run_frame(8'hD3, 24'h0, 32);
      chk("R8 R6 read after abort", 32'(rx_word), 32'h81F00D);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule